// File: doc/BRIEF.md
# Display Built-In Test Sequencer

This block runs the power-on test of a dot-matrix character display controller. After a reset, the host writes the configuration register with its start bit set. The register block turns that write into a one-cycle start strobe. From then on the sequencer keeps a busy flag high, and the controller refuses host accesses while it is high.

The test has two phases. In the first, the sequencer walks the font ROM through every glyph word, one word per clock. It adds the returned dot words together and compares the total with a constant fixed at build time. In the second, it tells the scan block to override the display with a checkerboard of dots, then with the inverse checkerboard.

The whole run has a fixed length. At the end, the sequencer fires a set of restore strobes in one cycle. These blank the text store, clear the per-digit blink bits, load the configuration register with only the result bit possibly set, and set the user-glyph pointer to all ones.

Top module: `self_test_seq`

## Requirements
- R1: While reset (synchronous, active high) is applied, and after it until a start is accepted, `busy_o`, `pat_en_o`, `pat_inv_o`, `pass_o` and all four restore strobes are 0.
- R2: A `start_i` pulse sampled while idle raises `busy_o` from the next cycle, and `busy_o` stays high for exactly TOTAL_CLKS cycles.
- R3: A `start_i` pulse sampled while `busy_o` is high, including in the last busy cycle, has no effect: the run length is unchanged and no new run begins.
- R4: The first NWORDS = N_CODES*ROWS busy cycles form the checksum phase. In busy cycle k of this phase, `rom_addr_o` equals k, which is the linear word index code*ROWS + row. `pat_en_o` is 0 during this phase.
- R5: The checksum is the sum, modulo 2^SUM_W, of `rom_data_i` (zero-extended) over all NWORDS words. `pass_o` is 1 only if this sum equals EXP_SUM.
- R6: The remaining busy cycles form the pattern phase, with `pat_en_o` high throughout. `pat_inv_o` is 0 (checkerboard) for the first HALF = (TOTAL_CLKS-NWORDS)/2 of these cycles and 1 (inverse checkerboard) for the rest.
- R7: `text_blank_o`, `blink_clr_o`, `cfg_wr_o` and `glyph_ptr_wr_o` pulse high together for exactly one cycle. That cycle is the first one in which `busy_o` is low after a completed run.
- R8: During the restore pulse, `cfg_data_o` has bit 5 equal to the test result and all other bits 0 (0x20 on pass, 0x00 on fail), and `glyph_ptr_o` is 4'b1111.
- R9: A reset during a run drops `busy_o` on the next cycle and produces no restore pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request (configuration write with start bit set) |
| busy_o | output | 1 | Test running; host access must be refused |
| rom_addr_o | output | ADDR_W | Font ROM word index during the checksum phase |
| rom_data_i | input | COLS | Dot word returned by the font ROM (combinational) |
| pat_en_o | output | 1 | Scan block must show the test pattern |
| pat_inv_o | output | 1 | 0: checkerboard, 1: inverse checkerboard |
| pass_o | output | 1 | Checksum result of the latest run |
| text_blank_o | output | 1 | Restore strobe: fill the text store with blanks |
| blink_clr_o | output | 1 | Restore strobe: clear all per-digit blink bits |
| cfg_wr_o | output | 1 | Restore strobe: load the configuration register |
| cfg_data_o | output | 8 | Value loaded into the configuration register |
| glyph_ptr_wr_o | output | 1 | Restore strobe: load the user-glyph pointer |
| glyph_ptr_o | output | 4 | Value loaded into the user-glyph pointer (all ones) |

## Verification
The bench builds the sequencer with TOTAL_CLKS=256, N_CODES=8, ROWS=7 and COLS=5. With these values a full run takes a few hundred cycles, so every phase boundary and the final restore cycle are visited cycle by cycle, several times over. SUM_W is cut to 8 so that the 56-word total wraps modulo 256, which exercises the modular compare. Corrupting one ROM word by 16 yields a guaranteed mismatch for the fail path. A start request placed in the very last busy cycle probes the idle/busy boundary.

// File: rtl/st_pkg.sv
package st_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SUM,
        PH_CHECKER,
        PH_INVERSE
    } st_phase_e;

    typedef struct packed {
        logic text_blank;
        logic blink_clr;
        logic cfg_wr;
        logic glyph_ptr_wr;
    } st_restore_t;

    localparam int unsigned CFG_W      = 8;
    localparam int unsigned RESULT_BIT = 5;
    localparam int unsigned GLYPH_W    = 4;

    // Which phase a given cycle of the run belongs to.
    function automatic st_phase_e phase_of(input logic busy,
                                           input int unsigned cnt,
                                           input int unsigned nwords,
                                           input int unsigned inv_start);
        if (!busy)
            return PH_IDLE;
        else if (cnt < nwords)
            return PH_SUM;
        else if (cnt < inv_start)
            return PH_CHECKER;
        else
            return PH_INVERSE;
    endfunction

endpackage

// File: rtl/st_timer.sv
module st_timer #(
    parameter int unsigned TOTAL_CLKS = 262144,
    localparam int unsigned CNT_W = $clog2(TOTAL_CLKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic             accept_o,
    output logic             finish_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL_CLKS - 1);

    assign accept_o = start_i && !busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            finish_o <= 1'b0;
            cnt_o    <= '0;
        end else begin
            finish_o <= 1'b0;
            if (accept_o) begin
                busy_o <= 1'b1;
                cnt_o  <= '0;
            end else if (busy_o) begin
                if (cnt_o == LAST) begin
                    busy_o   <= 1'b0;
                    finish_o <= 1'b1;
                    cnt_o    <= '0;
                end else begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/st_checksum.sv
module st_checksum
    import st_pkg::*;
#(
    parameter int unsigned SUM_W  = 16,
    parameter int unsigned DATA_W = 5,
    parameter int unsigned CNT_W  = 18,
    parameter int unsigned NWORDS = 896,
    parameter logic [SUM_W-1:0] EXP_SUM = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  st_phase_e         phase_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pass_o
);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;

    assign sum_next = sum_q + SUM_W'(data_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            pass_o <= 1'b0;
        end else if (clear_i) begin
            sum_q  <= '0;
            pass_o <= 1'b0;
        end else if (phase_i == PH_SUM) begin
            sum_q <= sum_next;
            if (cnt_i == CNT_W'(NWORDS - 1))
                pass_o <= (sum_next == EXP_SUM);
        end
    end

endmodule

// File: rtl/st_phase.sv
module st_phase
    import st_pkg::*;
#(
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NWORDS    = 896,
    parameter int unsigned INV_START = 131520
) (
    input  logic              busy_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output st_phase_e         phase_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              pat_en_o,
    output logic              pat_inv_o
);

    always_comb begin
        phase_o    = phase_of(busy_i, 32'(cnt_i), NWORDS, INV_START);
        rom_addr_o = (phase_o == PH_SUM) ? ADDR_W'(cnt_i) : '0;
        pat_en_o   = (phase_o == PH_CHECKER) || (phase_o == PH_INVERSE);
        pat_inv_o  = (phase_o == PH_INVERSE);
    end

endmodule

// File: rtl/self_test_seq.sv
module self_test_seq
    import st_pkg::*;
#(
    parameter int unsigned TOTAL_CLKS = 262144,
    parameter int unsigned N_CODES    = 128,
    parameter int unsigned ROWS       = 7,
    parameter int unsigned COLS       = 5,
    parameter int unsigned SUM_W      = 16,
    parameter logic [SUM_W-1:0] EXP_SUM = 16'h5A3C,
    localparam int unsigned NWORDS    = N_CODES * ROWS,
    localparam int unsigned ADDR_W    = $clog2(NWORDS),
    localparam int unsigned CNT_W     = $clog2(TOTAL_CLKS),
    localparam int unsigned HALF      = (TOTAL_CLKS - NWORDS) / 2,
    localparam int unsigned INV_START = NWORDS + HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic [COLS-1:0]   rom_data_i,
    output logic              pat_en_o,
    output logic              pat_inv_o,
    output logic              pass_o,
    output logic              text_blank_o,
    output logic              blink_clr_o,
    output logic              cfg_wr_o,
    output logic [7:0]        cfg_data_o,
    output logic              glyph_ptr_wr_o,
    output logic [3:0]        glyph_ptr_o
);

    logic             accept;
    logic             finish;
    logic [CNT_W-1:0] cnt;
    st_phase_e        phase;
    st_restore_t      restore;

    st_timer #(
        .TOTAL_CLKS(TOTAL_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .accept_o (accept),
        .finish_o (finish),
        .cnt_o    (cnt)
    );

    st_phase #(
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .NWORDS    (NWORDS),
        .INV_START (INV_START)
    ) u_phase (
        .busy_i     (busy_o),
        .cnt_i      (cnt),
        .phase_o    (phase),
        .rom_addr_o (rom_addr_o),
        .pat_en_o   (pat_en_o),
        .pat_inv_o  (pat_inv_o)
    );

    st_checksum #(
        .SUM_W   (SUM_W),
        .DATA_W  (COLS),
        .CNT_W   (CNT_W),
        .NWORDS  (NWORDS),
        .EXP_SUM (EXP_SUM)
    ) u_sum (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .phase_i (phase),
        .cnt_i   (cnt),
        .data_i  (rom_data_i),
        .pass_o  (pass_o)
    );

    // All restore strobes share the registered end-of-run pulse.
    always_comb begin
        restore = '{text_blank: finish, blink_clr: finish,
                    cfg_wr: finish, glyph_ptr_wr: finish};
        cfg_data_o             = '0;
        cfg_data_o[RESULT_BIT] = pass_o;
    end

    assign text_blank_o   = restore.text_blank;
    assign blink_clr_o    = restore.blink_clr;
    assign cfg_wr_o       = restore.cfg_wr;
    assign glyph_ptr_wr_o = restore.glyph_ptr_wr;
    assign glyph_ptr_o    = {GLYPH_W{1'b1}};

endmodule

// File: rtl/st_chk.sv
module st_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              pat_en_o,
    input logic              pat_inv_o,
    input logic              text_blank_o,
    input logic              blink_clr_o,
    input logic              cfg_wr_o,
    input logic [7:0]        cfg_data_o,
    input logic              glyph_ptr_wr_o,
    input logic [3:0]        glyph_ptr_o
);

    // R2
    run_starts_on_request_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R4
    walk_starts_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (rom_addr_o == '0) && !pat_en_o);

    // R6
    pattern_inside_run_chk: assert property (@(posedge clk) disable iff (rst)
        pat_en_o |-> busy_o);

    // R6
    inverse_follows_plain_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pat_inv_o) |-> $past(pat_en_o) && !$past(pat_inv_o));

    // R7
    restore_on_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_o |-> $fell(busy_o));

    // R7
    restore_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_o |=> !cfg_wr_o);

    // R7
    restore_together_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_o |-> text_blank_o && blink_clr_o && glyph_ptr_wr_o);

    // R8
    restore_values_chk: assert property (@(posedge clk) disable iff (rst)
        glyph_ptr_wr_o |-> ((cfg_data_o & 8'hDF) == 8'h00) && (glyph_ptr_o == 4'hF));

endmodule

bind self_test_seq st_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_self_test_seq.sv
module sim_self_test_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 256;
    localparam int NCODES     = 8;
    localparam int NROWS      = 7;
    localparam int NCOLS      = 5;
    localparam int SW         = 8;
    localparam int NW         = NCODES * NROWS;
    localparam int HALF       = (TOTAL - NW) / 2;

    function automatic logic [4:0] rom_fn(input int a);
        return 5'(((a * 13) + 5) ^ (a >> 2));
    endfunction

    function automatic logic [SW-1:0] golden();
        logic [SW-1:0] s = '0;
        for (int a = 0; a < NW; a++) s = s + SW'(rom_fn(a));
        return s;
    endfunction

    localparam logic [SW-1:0] EXP = golden();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       flip = 1'b0;
    logic       busy, pat_en, pat_inv, pass;
    logic       tblank, bclr, cwr, gwr;
    logic [7:0] cdata;
    logic [3:0] gptr;
    logic [$clog2(NW)-1:0] raddr;
    logic [4:0] rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Corruption adds or removes 16 on word 0: never a multiple of 256.
    assign rdata = rom_fn(int'(raddr)) ^ ((flip && raddr == '0) ? 5'h10 : 5'h00);

    self_test_seq #(
        .TOTAL_CLKS(TOTAL), .N_CODES(NCODES), .ROWS(NROWS),
        .COLS(NCOLS), .SUM_W(SW), .EXP_SUM(EXP)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy),
        .rom_addr_o(raddr), .rom_data_i(rdata),
        .pat_en_o(pat_en), .pat_inv_o(pat_inv), .pass_o(pass),
        .text_blank_o(tblank), .blink_clr_o(bclr),
        .cfg_wr_o(cwr), .cfg_data_o(cdata),
        .glyph_ptr_wr_o(gwr), .glyph_ptr_o(gptr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int strobes();
        return int'({tblank, bclr, cwr, gwr});
    endfunction

    task automatic t_reset_state();
        chk(!busy && !pat_en && !pat_inv && !pass, "R1", "flags in reset",
            int'({busy, pat_en, pat_inv, pass}), 0);
        chk(strobes() == 0, "R1", "strobes in reset", strobes(), 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && strobes() == 0, "R1", "idle after reset",
            int'(busy) + strobes(), 0);
    endtask

    // One full run; poke issues start requests while busy (R3).
    task automatic t_run(input bit corrupt, input bit poke, input bit exp_pass);
        int busy_cyc = 0, addr_err = 0, pat_err = 0, strb_err = 0;
        flip = corrupt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < TOTAL; j++) begin
            if (busy) busy_cyc++;
            if (j < NW) begin
                if (int'(raddr) != j || pat_en) addr_err++;
            end else begin
                if (!pat_en || pat_inv != (j >= NW + HALF)) pat_err++;
            end
            if (strobes() != 0) strb_err++;
            start = (poke && (j == 100 || j == TOTAL - 1));
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy_cyc == TOTAL, "R2", "busy length", busy_cyc, TOTAL);
        chk(addr_err == 0, "R4", "rom walk mismatches", addr_err, 0);
        chk(pat_err == 0, "R6", "pattern phase mismatches", pat_err, 0);
        chk(strb_err == 0, "R7", "strobes during run", strb_err, 0);
        chk(!busy && strobes() == 15, "R7", "restore pulse at busy fall",
            strobes(), 15);
        chk(cdata == (exp_pass ? 8'h20 : 8'h00), "R8", "cfg restore value",
            int'(cdata), exp_pass ? 32 : 0);
        chk(gptr == 4'hF, "R8", "glyph pointer restore", int'(gptr), 15);
        chk(pass == exp_pass, "R5", "checksum result", int'(pass), int'(exp_pass));
        @(negedge clk);
        chk(strobes() == 0, "R7", "restore lasts one cycle", strobes(), 0);
        chk(!busy, poke ? "R3" : "R2", "idle after run", int'(busy), 0);
        repeat (2) @(negedge clk);
        flip = 1'b0;
    endtask

    task automatic t_abort();
        int bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (70) @(negedge clk);
        chk(busy && pat_en, "R9", "running before abort", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy, "R9", "busy dropped by reset", int'(busy), 0);
        for (int j = 0; j < TOTAL + 20; j++) begin
            if (busy || strobes() != 0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9", "no restore after abort", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_run(1'b0, 1'b0, 1'b1);
        t_run(1'b1, 1'b0, 1'b0);
        t_run(1'b0, 1'b1, 1'b1);
        t_abort();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule